// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block is a purely combinational data path that moves a WIDTH-bit operand by one bit position or rotates it. Every output bit comes from its own 4-to-1 multiplexer, steered by a 2-bit select. In shift mode the select picks one of three operations: leave the operand unchanged, shift it right by one, or shift it left by one. A single mode bit decides what enters the vacated top bit on a right shift: zero (logical) or the old sign bit (arithmetic).

On an arithmetic left shift the unit raises a flag when the sign of the result differs from the sign of the operand, which means the doubled value does not fit. A separate rotate mode uses a second bank of per-bit multiplexers. It rotates the operand right by 0 to 3 places, with the same 2-bit select giving the rotate distance. The block is meant to sit in the execute stage of a small datapath, between operand registers owned by the surrounding logic.

Top module: `shift_rot_unit`

## Requirements
- R1: In shift mode (rot_i = 0), when sel_i[1] = 0 the result equals data_i, whatever the values of sel_i[0] and arith_i.
- R2: In shift mode, sel_i = 2'b10 moves every bit one place toward the LSB: result[i] = data_i[i+1] for i below WIDTH-1, and the old LSB is dropped.
- R3: On a right shift with arith_i = 0 the MSB of the result is 0.
- R4: On a right shift with arith_i = 1 the MSB of the result is a copy of data_i[WIDTH-1] (4'b1100 gives 4'b1110).
- R5: In shift mode, sel_i = 2'b11 moves every bit one place toward the MSB. The LSB of the result is 0 and the old MSB is dropped. arith_i does not change the result.
- R6: On a left shift with arith_i = 1, ovf_o is 1 exactly when result[WIDTH-1] differs from data_i[WIDTH-1] (4'b1011 gives 4'b0110 with ovf_o = 1).
- R7: ovf_o is 0 for pass-through, for right shifts, for logical left shifts and in rotate mode.
- R8: With rot_i = 1 the result is data_i rotated right by sel_i places, taken modulo WIDTH: result[i] = data_i[(i+sel_i) mod WIDTH], so sel_i = 1 on 4 bits gives {A0,A3,A2,A1}. arith_i has no effect in this mode.
- R9: The outputs follow input changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Operand |
| sel_i | input | 2 | Operation select in shift mode; rotate distance in rotate mode |
| arith_i | input | 1 | 1 = arithmetic fill and overflow detection; 0 = logical |
| rot_i | input | 1 | 1 = rotate mode, 0 = shift mode |
| data_o | output | WIDTH | Result |
| ovf_o | output | 1 | Sign change on arithmetic left shift |

## Verification
The embedded assertions re-check several properties whenever an input changes: the pass-through identity, the fill value of the top bit on a right shift, the zero entering at the bottom on a left shift, the relation between the flag and the sign bits, the flag staying low outside arithmetic left shifts, and that rotation keeps the number of set bits. Some properties can only be shown by the bench's exhaustive sweep against an operator-based reference. These are that each remaining bit lands in exactly the right position and that the rotate distance matches the select. The sweep also shows that outputs settle between clock edges with no clock involved.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;
  typedef enum logic [1:0] {
    OP_PASS0 = 2'b00,
    OP_PASS1 = 2'b01,
    OP_SHR   = 2'b10,
    OP_SHL   = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_lane_bank.sv
module shift_lane_bank #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [1:0]       sel_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] data_o
);
  logic fill_msb;
  assign fill_msb = arith_i & data_i[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic [3:0] cand;
    logic       right_src, left_src;
    if (i == WIDTH-1) begin : g_top
      assign right_src = fill_msb;
    end else begin : g_mid_r
      assign right_src = data_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign left_src = 1'b0;
    end else begin : g_mid_l
      assign left_src = data_i[i-1];
    end
    // encoding follows shift_rot_pkg::shift_op_e
    assign cand   = {left_src, right_src, data_i[i], data_i[i]};
    assign data_o[i] = cand[sel_i];
  end
endmodule

// File: rtl/rot_lane_bank.sv
module rot_lane_bank #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [1:0]       dist_i,
  output logic [WIDTH-1:0] data_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic [3:0] cand;
    for (genvar k = 0; k < 4; k++) begin : g_tap
      assign cand[k] = data_i[(i + k) % WIDTH];
    end
    assign data_o[i] = cand[dist_i];
  end
endmodule

// File: rtl/sign_change_det.sv
module sign_change_det #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             en_i,
  output logic             ovf_o
);
  assign ovf_o = en_i & (src_i[WIDTH-1] ^ res_i[WIDTH-1]);
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [1:0]       sel_i,
  input  logic             arith_i,
  input  logic             rot_i,
  output logic [WIDTH-1:0] data_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shift_res, rot_res;
  logic             chk_en;
  shift_op_e        op;

  assign op     = shift_op_e'(sel_i);
  assign chk_en = ~rot_i & arith_i & (op == OP_SHL);

  shift_lane_bank #(.WIDTH(WIDTH)) u_shift (
    .data_i (data_i),
    .sel_i  (sel_i),
    .arith_i(arith_i),
    .data_o (shift_res)
  );

  rot_lane_bank #(.WIDTH(WIDTH)) u_rot (
    .data_i(data_i),
    .dist_i(sel_i),
    .data_o(rot_res)
  );

  sign_change_det #(.WIDTH(WIDTH)) u_ovf (
    .src_i(data_i),
    .res_i(shift_res),
    .en_i (chk_en),
    .ovf_o(ovf_o)
  );

  assign data_o = rot_i ? rot_res : shift_res;

  always_comb begin
    if (!rot_i && !sel_i[1])
      AST_PASS_THRU: assert (data_o == data_i); // R1
    if (!rot_i && sel_i == 2'b10)
      AST_RIGHT_FILL: assert (data_o[MSB] == (arith_i & data_i[MSB])); // R3 R4
    if (!rot_i && sel_i == 2'b11)
      AST_LEFT_ZERO: assert (data_o[0] == 1'b0); // R5
    if (!rot_i && arith_i && sel_i == 2'b11)
      AST_OVF_SIGN: assert (ovf_o == (data_o[MSB] != data_i[MSB])); // R6
    if (ovf_o)
      AST_NO_OVERFLOW: assert (!rot_i && arith_i && sel_i == 2'b11); // R7
    if (rot_i)
      AST_ROT_POP: assert ($countones(data_o) == $countones(data_i)); // R8
  end
endmodule

// File: tb/shift_rot_unit_tb.sv
module shift_rot_unit_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [1:0]   sel_i = '0;
  logic         arith_i = 1'b0;
  logic         rot_i = 1'b0;
  logic [W-1:0] data_o;
  logic         ovf_o;
  int           errors = 0;
  int           checks = 0;
  int           cycles = 0;

  always #2.5 clk = ~clk; // 200 MHz

  shift_rot_unit #(.WIDTH(W)) u_dut (
    .data_i (data_i),
    .sel_i  (sel_i),
    .arith_i(arith_i),
    .rot_i  (rot_i),
    .data_o (data_o),
    .ovf_o  (ovf_o)
  );

  function automatic logic [W-1:0] ref_data(logic [W-1:0] d, logic [1:0] s,
                                             logic ar, logic rt);
    logic signed [W-1:0] sd;
    logic [2*W-1:0]      dd;
    sd = d;
    dd = {d, d} >> (s % W);
    if (rt) return dd[W-1:0];        // R8
    if (!s[1]) return d;             // R1
    if (s == 2'b10) return ar ? W'(sd >>> 1) : (d >> 1); // R2 R3 R4
    return d << 1;                   // R5
  endfunction

  function automatic logic ref_ovf(logic [W-1:0] d, logic [1:0] s,
                                   logic ar, logic rt);
    logic [W-1:0] r;
    r = d << 1;
    if (rt || !ar || s != 2'b11) return 1'b0; // R7
    return r[W-1] != d[W-1];                  // R6
  endfunction

  task automatic check(string tag, logic [W-1:0] act_d, logic [W-1:0] exp_d,
                       logic act_f, logic exp_f);
    checks++;
    if (act_d !== exp_d || act_f !== exp_f) begin
      errors++;
      $display("FAIL %s: data=%b ovf=%b expected data=%b ovf=%b",
               tag, act_d, act_f, exp_d, exp_f);
    end
  endtask

  function automatic string tag_of(logic [1:0] s, logic ar, logic rt);
    if (rt) return "R8";
    if (!s[1]) return "R1";
    if (s == 2'b10) return ar ? "R2/R4/R7" : "R2/R3/R7";
    return ar ? "R5/R6" : "R5/R7";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1 check("R1 idle", data_o, '0, ovf_o, 1'b0);

    // named corner cases
    rot_i = 0; arith_i = 1; sel_i = 2'b10; data_i = 4'b1100;
    #1 check("R4", data_o, 4'b1110, ovf_o, 1'b0);
    arith_i = 0;
    #1 check("R3", data_o, 4'b0110, ovf_o, 1'b0);
    arith_i = 1; sel_i = 2'b11; data_i = 4'b1011;
    #1 check("R6", data_o, 4'b0110, ovf_o, 1'b1);
    data_i = 4'b1101;
    #1 check("R6 no change", data_o, 4'b1010, ovf_o, 1'b0);
    arith_i = 0; data_i = 4'b1011;
    #1 check("R5 R7", data_o, 4'b0110, ovf_o, 1'b0);
    rot_i = 1; sel_i = 2'b01; data_i = 4'b0001;
    #1 check("R8 rot1", data_o, 4'b1000, ovf_o, 1'b0);
    arith_i = 1; sel_i = 2'b11; data_i = 4'b1000;
    #1 check("R8 rot3", data_o, 4'b0001, ovf_o, 1'b0);

    // exhaustive sweep, one combination per cycle; mid-cycle changes show R9
    for (int rt = 0; rt < 2; rt++)
      for (int ar = 0; ar < 2; ar++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < (1 << W); d++) begin
            @(negedge clk);
            data_i = W'(d); sel_i = 2'(s); arith_i = ar[0]; rot_i = rt[0];
            #1 check(tag_of(sel_i, arith_i, rot_i), data_o,
                     ref_data(data_i, sel_i, arith_i, rot_i), ovf_o,
                     ref_ovf(data_i, sel_i, arith_i, rot_i));
          end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule